// File: doc/BRIEF.md
# DDR Mode Register and Burst Column Sequencer

This block lives in the controller of a four-bank DDR memory. It watches the command bus for register-load commands and keeps a local copy of what the memory has been told: burst length, burst ordering, read latency, test and DLL-reset request bits, DLL disable and output drive selection. The rest of the controller reads these settings directly from the outputs.

When the controller begins a read or write burst it pulses `burst_start` with the first column. The block then emits one column address per clock in the order the memory uses internally. Fixed-length bursts wrap inside their aligned block, either counting upward or following the XOR pattern. Full-page bursts walk the whole 256-column row until the controller ends them. Register loads carrying codes that the memory does not support are refused and reported.

Top module: `ddr_mode_burst`

## Requirements
- R1: A register load is decoded when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising edge; `bank_sel` low targets the mode settings and high targets the extended settings; new values appear on the outputs in the following cycle. After reset: burst of 4, sequential, latency 3, all flag bits 0, drive 00, `illegal_set` 0, no burst running.
- R2: On a mode load `addr[2:0]` picks the burst length (001 = 2, 010 = 4, 011 = 8, 111 = full page, shown as 256 on `cfg_burst_beats`) and `addr[3]` picks the ordering (0 sequential, 1 interleaved).
- R3: On a mode load `addr[6:4]` picks the read latency (011 = 3, 100 = 4), `addr[7]` is copied to `cfg_test_mode` and `addr[8]` to `cfg_dll_reset`.
- R4: On an extended load `addr[0]` high disables the DLL (`cfg_dll_off` = 1) and `cfg_drive` = {`addr[6]`, `addr[1]`}; an extended load leaves all mode settings unchanged, and a mode load leaves the extended settings unchanged.
- R5: In a sequential burst of length BL, beat n carries the start column with its low log2(BL) bits replaced by (start + n) mod BL; the upper bits do not change.
- R6: In an interleaved burst, beat n carries the start column with its low log2(BL) bits XORed with n.
- R7: A full-page burst emits start + n modulo 256, never raises `beat_last`, and keeps going until `burst_stop` is high at a rising edge; a full-page start at an odd column is refused and leaves `beat_valid` as it was.
- R8: A mode load with a reserved length code, a reserved latency code, or interleaved ordering with full page is discarded whole and sets `illegal_set`; the next accepted mode load clears it; extended loads do not touch it.
- R9: After any decoded register load, `mode_busy` is high for one cycle and a register load or burst start presented at that next edge is ignored.
- R10: A burst keeps the length and ordering in force at the edge where it starts; a mode load at that same edge applies only to later bursts.
- R11: `beat_last` is high on the final beat of a fixed-length burst and `beat_valid` is low in the cycle after it; `burst_stop` ends any burst; a start accepted during a burst restarts at the new column, and wins over `burst_stop` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Bank bit 0: 0 mode, 1 extended |
| addr | input | 9 | Address bits carrying the register fields |
| burst_start | input | 1 | Begin a burst at `burst_col` |
| burst_col | input | 8 | First column of the burst |
| burst_stop | input | 1 | End the running burst |
| cfg_burst_beats | output | 9 | Burst length in beats (2, 4, 8, 256) |
| cfg_interleave | output | 1 | 1 = interleaved ordering |
| cfg_read_latency | output | 3 | Read latency in clocks |
| cfg_test_mode | output | 1 | Stored test-mode bit |
| cfg_dll_reset | output | 1 | Stored DLL-reset request bit |
| cfg_dll_off | output | 1 | 1 = DLL disabled |
| cfg_drive | output | 2 | Drive-strength selection |
| illegal_set | output | 1 | Last mode load was refused |
| mode_busy | output | 1 | Guard cycle after a register load |
| beat_valid | output | 1 | A beat column is present |
| beat_col | output | 8 | Column of the current beat |
| beat_last | output | 1 | Final beat of a fixed burst |

## Verification
A mode load and a burst start can land on the same rising edge, so the running burst and the stored settings diverge at once. The bench provokes this by loading a length of 8 while launching a burst under the older length of 4, then judges that the burst ends after four beats while the outputs already show 8, and that the next burst uses 8. A second overlap, a load or start falling inside the guard cycle, is provoked back to back and judged by unchanged settings and an idle beat output.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

    localparam int COL_W  = 8;
    localparam int ADDR_W = 9;
    localparam int BEAT_W = COL_W + 1;

    localparam logic [2:0] BLC_2    = 3'b001;
    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam logic [2:0] BLC_FULL = 3'b111;
    localparam logic [2:0] LTC_3    = 3'b011;
    localparam logic [2:0] LTC_4    = 3'b100;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_MODE = 2'd1,
        RC_EXT  = 2'd2
    } regcmd_e;

    typedef struct packed {
        logic [2:0] blen;
        logic       ileave;
        logic [2:0] lat;
        logic       test_mode;
        logic       dll_rst;
    } mode_cfg_t;

    typedef struct packed {
        logic       dll_off;
        logic [1:0] drive;
    } ext_cfg_t;

    localparam mode_cfg_t MODE_RESET = '{blen: BLC_4, ileave: 1'b0, lat: LTC_3,
                                         test_mode: 1'b0, dll_rst: 1'b0};
    localparam ext_cfg_t  EXT_RESET  = '{dll_off: 1'b0, drive: 2'b00};

    function automatic logic blen_legal(input logic [2:0] code);
        return (code == BLC_2) || (code == BLC_4) || (code == BLC_8) || (code == BLC_FULL);
    endfunction

    function automatic logic lat_legal(input logic [2:0] code);
        return (code == LTC_3) || (code == LTC_4);
    endfunction

    function automatic logic [COL_W-1:0] blen_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            BLC_2:    m = COL_W'(1);
            BLC_4:    m = COL_W'(3);
            BLC_8:    m = COL_W'(7);
            default:  m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [BEAT_W-1:0] blen_beats(input logic [2:0] code);
        return {1'b0, blen_mask(code)} + BEAT_W'(1);
    endfunction

    function automatic logic [2:0] lat_cycles(input logic [2:0] code);
        return (code == LTC_4) ? 3'd4 : 3'd3;
    endfunction

endpackage

// File: rtl/mrb_cmd_decode.sv
module mrb_cmd_decode
    import mrb_pkg::*;
#(
    parameter int GAP_CYCLES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    input  logic    bank_sel,
    input  logic    start_req,
    output regcmd_e cmd_kind,
    output logic    burst_go,
    output logic    busy
);

    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GUARD_LOAD = GW'(GAP_CYCLES - 1);

    logic [GW-1:0] guard_cnt;
    logic          is_load;

    assign is_load  = !cs_n && !ras_n && !cas_n && !we_n;
    assign busy     = (guard_cnt != '0);
    assign burst_go = start_req && !busy;

    always_comb begin
        cmd_kind = RC_NONE;
        if (is_load && !busy) begin
            cmd_kind = bank_sel ? RC_EXT : RC_MODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_cnt <= '0;
        end else if (cmd_kind != RC_NONE) begin
            guard_cnt <= GUARD_LOAD;
        end else if (guard_cnt != '0) begin
            guard_cnt <= guard_cnt - GW'(1);
        end
    end

    generate
        if (GAP_CYCLES > 1) begin : g_guard_chk
            // R9: a decoded load is always followed by a guard cycle
            a_r9_guard_follows: assert property (@(posedge clk) disable iff (rst)
                (cmd_kind != RC_NONE) |=> busy);
            // R9: guard cycle blocks the next load or start
            a_r9_guard_blocks: assert property (@(posedge clk) disable iff (rst)
                ($past(cmd_kind) != RC_NONE) |-> (cmd_kind == RC_NONE && !burst_go));
        end
    endgenerate

endmodule

// File: rtl/mrb_mode_store.sv
module mrb_mode_store
    import mrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  regcmd_e           cmd_kind,
    input  logic [ADDR_W-1:0] addr,
    output mode_cfg_t         mcfg,
    output ext_cfg_t          ecfg,
    output logic              illegal
);

    mode_cfg_t cand_mode;
    ext_cfg_t  cand_ext;
    logic      cand_ok;

    always_comb begin
        cand_mode.blen      = addr[2:0];
        cand_mode.ileave    = addr[3];
        cand_mode.lat       = addr[6:4];
        cand_mode.test_mode = addr[7];
        cand_mode.dll_rst   = addr[8];
        cand_ext.dll_off    = addr[0];
        cand_ext.drive      = {addr[6], addr[1]};
        cand_ok = blen_legal(cand_mode.blen) && lat_legal(cand_mode.lat)
                  && !(cand_mode.ileave && cand_mode.blen == BLC_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcfg    <= MODE_RESET;
            ecfg    <= EXT_RESET;
            illegal <= 1'b0;
        end else begin
            case (cmd_kind)
                RC_MODE: begin
                    illegal <= !cand_ok;
                    if (cand_ok) begin
                        mcfg <= cand_mode;
                    end
                end
                RC_EXT: begin
                    ecfg <= cand_ext;
                end
                default: begin
                end
            endcase
        end
    end

    // R8: stored settings are never a reserved or forbidden combination
    a_r8_stored_legal: assert property (@(posedge clk) disable iff (rst)
        blen_legal(mcfg.blen) && lat_legal(mcfg.lat)
        && !(mcfg.ileave && mcfg.blen == BLC_FULL));
    // R8: a refused mode load keeps the old settings and raises the flag
    a_r8_refused_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == RC_MODE && !cand_ok) |=> ($stable(mcfg) && illegal));
    // R4: an extended load leaves mode fields and the flag alone
    a_r4_ext_isolated: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind == RC_EXT) |=> ($stable(mcfg) && $stable(illegal)));

endmodule

// File: rtl/mrb_burst_gen.sv
module mrb_burst_gen
    import mrb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    input  logic [2:0]       cur_blen,
    input  logic             cur_ileave,
    output logic             valid,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic             active;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] mask_q;
    logic             ileave_q;
    logic             full_q;
    logic             cur_full;
    logic             go_ok;

    assign cur_full = (cur_blen == BLC_FULL);
    assign go_ok    = go && !(cur_full && start_col[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            mask_q   <= '0;
            ileave_q <= 1'b0;
            full_q   <= 1'b0;
        end else if (go_ok) begin
            active   <= 1'b1;
            base_q   <= start_col;
            cnt_q    <= '0;
            mask_q   <= blen_mask(cur_blen);
            ileave_q <= cur_ileave;
            full_q   <= cur_full;
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                cnt_q <= cnt_q + COL_W'(1);
            end
        end
    end

    always_comb begin
        if (ileave_q) begin
            col = base_q ^ (cnt_q & mask_q);
        end else begin
            col = (base_q & ~mask_q) | ((base_q + cnt_q) & mask_q);
        end
    end

    assign valid = active;
    assign last  = active && !full_q && (cnt_q == mask_q);

    // R5/R6: bits above the burst block never move within a burst
    a_r5_block_fixed: assert property (@(posedge clk) disable iff (rst)
        (valid && !last && !stop && !go) |=>
        (valid && ((col & ~mask_q) == ($past(col) & ~mask_q))));
    // R7: a full-page burst steps one column per clock
    a_r7_page_step: assert property (@(posedge clk) disable iff (rst)
        (valid && full_q && !stop && !go) |=> (valid && col == $past(col) + COL_W'(1)));
    // R11: final beat is followed by idle unless a new burst starts
    a_r11_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (last && !go) |=> !valid);
    // R7: a refused odd full-page start leaves the output unchanged
    a_r7_odd_refused: assert property (@(posedge clk) disable iff (rst)
        (go && cur_full && start_col[0] && !valid) |=> !valid);

endmodule

// File: rtl/ddr_mode_burst.sv
module ddr_mode_burst
    import mrb_pkg::*;
#(
    parameter int GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_start,
    input  logic [COL_W-1:0]  burst_col,
    input  logic              burst_stop,
    output logic [BEAT_W-1:0] cfg_burst_beats,
    output logic              cfg_interleave,
    output logic [2:0]        cfg_read_latency,
    output logic              cfg_test_mode,
    output logic              cfg_dll_reset,
    output logic              cfg_dll_off,
    output logic [1:0]        cfg_drive,
    output logic              illegal_set,
    output logic              mode_busy,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_last
);

    regcmd_e   cmd_kind;
    logic      burst_go;
    mode_cfg_t mcfg;
    ext_cfg_t  ecfg;

    mrb_cmd_decode #(.GAP_CYCLES(GAP_CYCLES)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_sel (bank_sel),
        .start_req(burst_start),
        .cmd_kind (cmd_kind),
        .burst_go (burst_go),
        .busy     (mode_busy)
    );

    mrb_mode_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd_kind(cmd_kind),
        .addr    (addr),
        .mcfg    (mcfg),
        .ecfg    (ecfg),
        .illegal (illegal_set)
    );

    mrb_burst_gen u_burst (
        .clk       (clk),
        .rst       (rst),
        .go        (burst_go),
        .start_col (burst_col),
        .stop      (burst_stop),
        .cur_blen  (mcfg.blen),
        .cur_ileave(mcfg.ileave),
        .valid     (beat_valid),
        .col       (beat_col),
        .last      (beat_last)
    );

    assign cfg_burst_beats  = blen_beats(mcfg.blen);
    assign cfg_interleave   = mcfg.ileave;
    assign cfg_read_latency = lat_cycles(mcfg.lat);
    assign cfg_test_mode    = mcfg.test_mode;
    assign cfg_dll_reset    = mcfg.dll_rst;
    assign cfg_dll_off      = ecfg.dll_off;
    assign cfg_drive        = ecfg.drive;

    // R3: latency output is always one of the two supported values
    a_r3_latency_range: assert property (@(posedge clk) disable iff (rst)
        (cfg_read_latency == 3'd3) || (cfg_read_latency == 3'd4));
    // R2: interleaved ordering never coexists with full page
    a_r2_no_ileave_page: assert property (@(posedge clk) disable iff (rst)
        !(cfg_interleave && cfg_burst_beats == BEAT_W'(256)));
    // R1: settings only move after a load decoded outside the guard cycle
    a_r1_change_needs_load: assert property (@(posedge clk) disable iff (rst)
        !$stable({cfg_burst_beats, cfg_interleave, cfg_read_latency, cfg_dll_off, cfg_drive})
        |-> ($past(!cs_n && !ras_n && !cas_n && !we_n) && !$past(mode_busy)));

endmodule

// File: tb/sim_ddr_mode_burst.sv
module sim_ddr_mode_burst;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       bank_sel = 1'b0;
    logic [8:0] addr = '0;
    logic       burst_start = 1'b0;
    logic [7:0] burst_col = '0;
    logic       burst_stop = 1'b0;
    logic [8:0] cfg_burst_beats;
    logic       cfg_interleave;
    logic [2:0] cfg_read_latency;
    logic       cfg_test_mode, cfg_dll_reset, cfg_dll_off;
    logic [1:0] cfg_drive;
    logic       illegal_set, mode_busy, beat_valid, beat_last;
    logic [7:0] beat_col;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ddr_mode_burst u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_sel(bank_sel), .addr(addr), .burst_start(burst_start), .burst_col(burst_col),
        .burst_stop(burst_stop), .cfg_burst_beats(cfg_burst_beats),
        .cfg_interleave(cfg_interleave), .cfg_read_latency(cfg_read_latency),
        .cfg_test_mode(cfg_test_mode), .cfg_dll_reset(cfg_dll_reset),
        .cfg_dll_off(cfg_dll_off), .cfg_drive(cfg_drive), .illegal_set(illegal_set),
        .mode_busy(mode_busy), .beat_valid(beat_valid), .beat_col(beat_col),
        .beat_last(beat_last)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int n, input int bl, input bit il);
        int base;
        int off;
        if (bl == 256) return (s + n) % 256;
        base = s - (s % bl);
        off  = s % bl;
        if (il) return base + (off ^ n);
        return base + ((off + n) % bl);
    endfunction

    function automatic logic [8:0] mode_word(input logic [2:0] bl, input bit il,
                                             input logic [2:0] lt);
        return {2'b00, lt, il, bl};
    endfunction

    // drive a load at the current negedge; returns at the next negedge
    task automatic drive_load(input bit ext, input logic [8:0] a);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
        bank_sel = ext; addr = a;
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        bank_sel = 1'b0; addr = '0;
    endtask

    task automatic load_and_settle(input bit ext, input logic [8:0] a);
        drive_load(ext, a);
        @(negedge clk);
    endtask

    task automatic run_fixed(input string tag, input int s, input int bl, input bit il);
        burst_start = 1'b1; burst_col = 8'(s);
        @(negedge clk);
        burst_start = 1'b0;
        for (int i = 0; i < bl; i++) begin
            check({tag, " valid"}, beat_valid, 1);
            check({tag, " col"}, beat_col, exp_col(s, i, bl, il));
            check({tag, " last"}, beat_last, (i == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        check({tag, " idle after"}, beat_valid, 0);
    endtask

    task automatic t_reset();
        check("R1 reset beats", cfg_burst_beats, 4);
        check("R1 reset type", cfg_interleave, 0);
        check("R1 reset latency", cfg_read_latency, 3);
        check("R1 reset dll_off", cfg_dll_off, 0);
        check("R1 reset drive", cfg_drive, 0);
        check("R1 reset illegal", illegal_set, 0);
        check("R1 reset valid", beat_valid, 0);
    endtask

    task automatic t_mode_fields();
        drive_load(1'b0, {1'b1, 1'b1, 3'b100, 1'b0, 3'b011});
        check("R2 beats 8", cfg_burst_beats, 8);
        check("R3 latency 4", cfg_read_latency, 4);
        check("R3 test bit", cfg_test_mode, 1);
        check("R3 dll reset bit", cfg_dll_reset, 1);
        check("R9 busy", mode_busy, 1);
        @(negedge clk);
        check("R9 busy cleared", mode_busy, 0);
        load_and_settle(1'b0, mode_word(3'b011, 1'b0, 3'b011));
        check("R3 latency 3", cfg_read_latency, 3);
        check("R3 test cleared", cfg_test_mode, 0);
    endtask

    task automatic t_seq();
        run_fixed("R5 seq8", 8'h35, 8, 1'b0);
        load_and_settle(1'b0, mode_word(3'b001, 1'b0, 3'b011));
        check("R2 beats 2", cfg_burst_beats, 2);
        run_fixed("R5 seq2", 8'h9B, 2, 1'b0);
    endtask

    task automatic t_ileave();
        load_and_settle(1'b0, mode_word(3'b010, 1'b1, 3'b011));
        check("R2 interleave", cfg_interleave, 1);
        run_fixed("R6 il4", 8'h2E, 4, 1'b1);
        load_and_settle(1'b0, mode_word(3'b011, 1'b1, 3'b011));
        run_fixed("R6 il8", 8'h45, 8, 1'b1);
    endtask

    task automatic t_fullpage();
        load_and_settle(1'b0, mode_word(3'b111, 1'b0, 3'b100));
        check("R2 beats page", cfg_burst_beats, 256);
        burst_start = 1'b1; burst_col = 8'hFC;
        @(negedge clk);
        burst_start = 1'b0;
        for (int i = 0; i < 7; i++) begin
            check("R7 page valid", beat_valid, 1);
            check("R7 page col", beat_col, exp_col(8'hFC, i, 256, 1'b0));
            check("R7 page no last", beat_last, 0);
            if (i == 6) burst_stop = 1'b1;
            @(negedge clk);
        end
        burst_stop = 1'b0;
        check("R7 stopped", beat_valid, 0);
        burst_start = 1'b1; burst_col = 8'h11;
        @(negedge clk);
        burst_start = 1'b0;
        check("R7 odd start refused", beat_valid, 0);
    endtask

    task automatic t_illegal();
        load_and_settle(1'b0, mode_word(3'b010, 1'b0, 3'b011));
        drive_load(1'b0, mode_word(3'b101, 1'b0, 3'b011));
        check("R8 bad length flag", illegal_set, 1);
        check("R8 bad length kept", cfg_burst_beats, 4);
        @(negedge clk);
        load_and_settle(1'b1, 9'h043);
        check("R8 ext keeps flag", illegal_set, 1);
        drive_load(1'b0, mode_word(3'b011, 1'b0, 3'b010));
        check("R8 bad latency kept beats", cfg_burst_beats, 4);
        check("R8 bad latency kept lat", cfg_read_latency, 3);
        @(negedge clk);
        load_and_settle(1'b0, mode_word(3'b111, 1'b1, 3'b100));
        check("R8 il+page flag", illegal_set, 1);
        check("R8 il+page kept type", cfg_interleave, 0);
        check("R8 il+page kept beats", cfg_burst_beats, 4);
        load_and_settle(1'b0, mode_word(3'b011, 1'b0, 3'b011));
        check("R8 flag cleared", illegal_set, 0);
        check("R8 accepted", cfg_burst_beats, 8);
    endtask

    task automatic t_ext();
        load_and_settle(1'b1, 9'h043);
        check("R4 dll off", cfg_dll_off, 1);
        check("R4 drive", cfg_drive, 3);
        check("R4 mode untouched", cfg_burst_beats, 8);
        load_and_settle(1'b1, 9'h002);
        check("R4 dll on", cfg_dll_off, 0);
        check("R4 drive 01", cfg_drive, 1);
        load_and_settle(1'b0, mode_word(3'b010, 1'b0, 3'b011));
        check("R4 ext untouched", cfg_drive, 1);
    endtask

    task automatic t_guard();
        drive_load(1'b0, mode_word(3'b001, 1'b0, 3'b011));
        check("R9 busy in gap", mode_busy, 1);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
        addr = mode_word(3'b011, 1'b0, 3'b100);
        burst_start = 1'b1; burst_col = 8'h20;
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0;
        burst_start = 1'b0;
        check("R9 load in gap ignored", cfg_burst_beats, 2);
        check("R9 latency unchanged", cfg_read_latency, 3);
        check("R9 start in gap ignored", beat_valid, 0);
    endtask

    task automatic t_overlap();
        load_and_settle(1'b0, mode_word(3'b010, 1'b0, 3'b011));
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
        addr = mode_word(3'b011, 1'b0, 3'b011);
        burst_start = 1'b1; burst_col = 8'h12;
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0;
        burst_start = 1'b0;
        check("R10 new setting visible", cfg_burst_beats, 8);
        for (int i = 0; i < 4; i++) begin
            check("R10 old-length col", beat_col, exp_col(8'h12, i, 4, 1'b0));
            check("R10 old-length last", beat_last, (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R10 ended at 4", beat_valid, 0);
        run_fixed("R10 next uses 8", 8'h12, 8, 1'b0);
    endtask

    task automatic t_restart();
        burst_start = 1'b1; burst_col = 8'h40;
        @(negedge clk);
        burst_start = 1'b0;
        @(negedge clk);
        check("R11 running", beat_col, 8'h41);
        burst_start = 1'b1; burst_col = 8'h5C; burst_stop = 1'b1;
        @(negedge clk);
        burst_start = 1'b0; burst_stop = 1'b0;
        check("R11 restart valid", beat_valid, 1);
        check("R11 restart col", beat_col, 8'h5C);
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R11 stop fixed burst", beat_valid, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode_fields();
        t_seq();
        t_ileave();
        t_fullpage();
        t_illegal();
        t_ext();
        t_guard();
        t_overlap();
        t_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule